// File: doc/BRIEF.md
# CEC frame receiver with destination filter

This block listens to a single-wire CEC bus and turns the pulse-width coded line activity into bytes. All timing decisions are made by counting ticks from a local tick generator. The bit-window limits arrive as tick counts on input ports, so software can map them onto a 25 µs tick or onto any other tick rate. A frame begins with a long start pulse, followed by ten-bit byte slots: eight data bits sent MSB first, an end-of-message bit and an acknowledge slot.

The low nibble of the first byte is the destination. The receiver keeps a frame only when that nibble equals the programmed logical address or is the broadcast value 0xF. For a frame addressed directly to the device, it stretches every acknowledge slot low. For broadcast frames it leaves the acknowledge slots alone. Up to 16 bytes are stored, packed little-end first into a 128-bit data bus. Any later bytes are still acknowledged but are dropped.

When the frame ends, the block raises end-of-message, status, interrupt and a receive-source flag, and it presents the stored byte count minus one. It then stays stalled, ignoring the bus, until software pulses the clear-receive input.

Top module: `cec_frame_rx`

## Requirements
- R1: After reset, rx_eom_o, rx_good_o, rx_irq_o, rx_src_o, rx_cnt_o and cec_pull_o are all 0, and the receiver is armed.
- R2: A start pulse is accepted only if its low time lies within [start_lo_min_i, start_lo_max_i] ticks and the time to the next falling edge lies within [start_per_min_i, start_per_max_i] ticks. Otherwise the frame is dropped: no acknowledge and no report.
- R3: One tick occurs every clk_div_i clocks (0 or 1 means every clock). A data bit reads as 1 if the line is high sample_pt_i ticks after its falling edge, and as 0 if it is still low. Bits arrive MSB first.
- R4: A frame is kept only if bits [3:0] of its first byte equal log_addr_i or 0xF. Any other frame is neither acknowledged nor reported, and the stored data does not change.
- R5: For a kept frame whose destination is not 0xF, cec_pull_o holds the line low from the falling edge of each acknowledge slot until ack_len_i ticks have passed. For a broadcast frame, the line is never pulled.
- R6: Byte k of the frame appears at rx_data_o[8k+7:8k], so the first byte sits in the least significant byte of the first 32-bit word.
- R7: rx_cnt_o reports the number of stored bytes minus one, in the range 0 to 15.
- R8: Bytes after the 16th are still acknowledged but not stored, and rx_cnt_o stays at 15.
- R9: When the acknowledge slot of a byte whose end-of-message bit was 1 completes, rx_eom_o, rx_good_o, rx_irq_o and rx_src_o are set to 1.
- R10: After the first byte has been kept, a data-bit low time longer than bit_lo_max_i ticks ends the frame with rx_eom_o=1, rx_good_o=0, rx_irq_o=1.
- R11: Once a frame is reported, the bus is ignored (no acknowledge, data unchanged) until clr_rx_i is pulsed. While clr_rx_i is 1 all flags read 0, and reception resumes after clr_rx_i returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_div_i | input | 12 | Clocks per tick |
| cec_i | input | 1 | Bus line level (asynchronous) |
| cec_pull_o | output | 1 | 1 pulls the bus line low |
| log_addr_i | input | 4 | Device logical address, 0xF means unregistered |
| clr_rx_i | input | 1 | Clear-receive control, pulse to re-arm |
| start_lo_min_i | input | 8 | Minimum start low time, ticks |
| start_lo_max_i | input | 8 | Maximum start low time, ticks |
| start_per_min_i | input | 8 | Minimum start period, ticks |
| start_per_max_i | input | 8 | Maximum start period, ticks |
| sample_pt_i | input | 8 | Data sample point after falling edge, ticks |
| ack_len_i | input | 8 | Acknowledge drive length, ticks |
| bit_lo_max_i | input | 8 | Longest legal data-bit low time, ticks |
| rx_eom_o | output | 1 | Frame ended |
| rx_good_o | output | 1 | Frame ended cleanly |
| rx_irq_o | output | 1 | Interrupt request |
| rx_src_o | output | 1 | Interrupt was caused by reception |
| rx_cnt_o | output | 4 | Stored bytes minus one |
| rx_data_o | output | 128 | Stored bytes, byte k at bits 8k+7:8k |

## Verification
A bus edge reaches the bit state machine three clocks after it is driven: two synchronizer stages plus the edge register. The acknowledge pull therefore starts a few clocks after the slot's falling edge and drops just after ack_len_i ticks. The bench reads the bus in the middle of that window, at 42 ticks, and again well after it, at 70 ticks. The flags and the count settle about 60 ticks into the final acknowledge slot, and the bench reads them only after that slot's full 96 ticks have passed. The effect of clr_rx_i is read three clocks after it rises. Sample-point checks use lows 4 ticks on either side of the threshold, which is 8 clocks of margin against the tick phase.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;
  localparam int unsigned TW = 8;
  typedef logic [TW-1:0] tick_cnt_t;

  typedef struct packed {
    tick_cnt_t lo_min;
    tick_cnt_t lo_max;
    tick_cnt_t per_min;
    tick_cnt_t per_max;
    tick_cnt_t sample;
    tick_cnt_t ack_len;
    tick_cnt_t bit_lo_max;
  } thr_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SLOW, ST_SHIGH, ST_BLOW, ST_BWAIT, ST_ACK, ST_DONE, ST_CLR
  } rx_state_e;

  localparam logic [3:0] ADDR_BCAST = 4'hF;
endpackage

// File: rtl/cec_tick_gen.sv
module cec_tick_gen #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = ({1'b0, cnt_q} + (DIV_W+1)'(1)) >= {1'b0, div_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  a_r3_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i > DIV_W'(1) && $stable(div_i)) |=> (!tick_o || div_i <= DIV_W'(1)));
endmodule

// File: rtl/cec_line_sync.sv
module cec_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b1;
      else if (g == 0) sync_q[g] <= line_i;
      else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign line_o = sync_q[STAGES-1];
  assign fall_o = prev_q & ~line_o;
  assign rise_o = ~prev_q & line_o;
endmodule

// File: rtl/cec_rx_core.sv
module cec_rx_core
  import cec_rx_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 16,
  localparam int unsigned IW = $clog2(MAX_BYTES),
  localparam int unsigned CW = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic                   line_i,
  input  logic                   fall_i,
  input  logic                   rise_i,
  input  logic [3:0]             log_addr_i,
  input  thr_t                   thr_i,
  input  logic                   clr_rx_i,
  output logic                   pull_o,
  output logic                   eom_o,
  output logic                   good_o,
  output logic                   irq_o,
  output logic                   src_o,
  output logic [IW-1:0]          cnt_o,
  output logic [MAX_BYTES*8-1:0] data_o
);
  rx_state_e state_q;
  tick_cnt_t tcnt_q;
  logic [3:0]    idx_q;
  logic [6:0]    shift_q;
  logic [CW-1:0] bcnt_q;
  logic hdr_ok_q, ack_en_q, eom_bit_q, pull_q;
  logic eom_q, good_q, irq_q, src_q;
  logic [IW-1:0] cnt_q;
  logic [7:0] mem_q [MAX_BYTES];

  logic       sample_now, byte_done, dst_hit, accept, wr_en, lo_viol;
  logic       lo_ok, per_ok;
  logic [7:0] byte_nxt;

  assign sample_now = (state_q == ST_BLOW) && (tcnt_q >= thr_i.sample);
  assign byte_nxt   = {shift_q, line_i};
  assign byte_done  = sample_now && (idx_q == 4'd7);
  assign dst_hit    = (byte_nxt[3:0] == ADDR_BCAST) || (byte_nxt[3:0] == log_addr_i);
  assign accept     = byte_done && (hdr_ok_q || dst_hit);
  assign wr_en      = accept && (bcnt_q < CW'(MAX_BYTES));
  assign lo_viol    = (state_q == ST_BWAIT) && !line_i && (tcnt_q > thr_i.bit_lo_max);
  assign lo_ok      = (tcnt_q >= thr_i.lo_min) && (tcnt_q <= thr_i.lo_max);
  assign per_ok     = (tcnt_q >= thr_i.per_min) && (tcnt_q <= thr_i.per_max);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      tcnt_q    <= '0;
      idx_q     <= '0;
      shift_q   <= '0;
      bcnt_q    <= '0;
      hdr_ok_q  <= 1'b0;
      ack_en_q  <= 1'b0;
      eom_bit_q <= 1'b0;
      pull_q    <= 1'b0;
      eom_q     <= 1'b0;
      good_q    <= 1'b0;
      irq_q     <= 1'b0;
      src_q     <= 1'b0;
      cnt_q     <= '0;
    end else begin
      if (fall_i)                         tcnt_q <= '0;
      else if (tick_i && tcnt_q != '1)    tcnt_q <= tcnt_q + 1'b1;

      unique case (state_q)
        ST_IDLE: begin
          if (clr_rx_i)    state_q <= ST_CLR;
          else if (fall_i) state_q <= ST_SLOW;
        end
        ST_SLOW: begin
          if (rise_i)                        state_q <= lo_ok ? ST_SHIGH : ST_IDLE;
          else if (tcnt_q > thr_i.lo_max)    state_q <= ST_IDLE;
        end
        ST_SHIGH: begin
          if (fall_i) begin
            if (per_ok) begin
              state_q  <= ST_BLOW;
              idx_q    <= '0;
              bcnt_q   <= '0;
              hdr_ok_q <= 1'b0;
              ack_en_q <= 1'b0;
            end else begin
              state_q  <= ST_SLOW;  // that edge may open a new start
            end
          end else if (tcnt_q > thr_i.per_max) begin
            state_q <= ST_IDLE;
          end
        end
        ST_BLOW: begin
          if (sample_now) begin
            shift_q <= byte_nxt[6:0];
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_BWAIT;
            if (idx_q == 4'd8) eom_bit_q <= line_i;
            if (byte_done && !hdr_ok_q) begin
              if (dst_hit) begin
                hdr_ok_q <= 1'b1;
                ack_en_q <= (byte_nxt[3:0] != ADDR_BCAST);
              end else begin
                state_q  <= ST_IDLE;
              end
            end
            if (accept && bcnt_q != CW'(MAX_BYTES)) bcnt_q <= bcnt_q + 1'b1;
          end
        end
        ST_BWAIT: begin
          if (fall_i) begin
            if (idx_q == 4'd9) begin
              state_q <= ST_ACK;
              pull_q  <= ack_en_q;
            end else begin
              state_q <= ST_BLOW;
            end
          end else if (lo_viol) begin
            if (hdr_ok_q) begin
              state_q <= ST_DONE;
              eom_q   <= 1'b1;
              good_q  <= 1'b0;
              irq_q   <= 1'b1;
              src_q   <= 1'b1;
              cnt_q   <= IW'(bcnt_q - 1'b1);
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (tcnt_q >= thr_i.ack_len) begin
            pull_q <= 1'b0;
            if (eom_bit_q) begin
              state_q <= ST_DONE;
              eom_q   <= 1'b1;
              good_q  <= 1'b1;
              irq_q   <= 1'b1;
              src_q   <= 1'b1;
              cnt_q   <= IW'(bcnt_q - 1'b1);
            end else begin
              idx_q   <= '0;
              state_q <= ST_BWAIT;
            end
          end
        end
        ST_DONE: begin
          if (clr_rx_i) state_q <= ST_CLR;
        end
        ST_CLR: begin
          if (!clr_rx_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase

      if (clr_rx_i) begin
        eom_q  <= 1'b0;
        good_q <= 1'b0;
        irq_q  <= 1'b0;
        src_q  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(MAX_BYTES); i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[bcnt_q[IW-1:0]] <= byte_nxt;
    end
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_out
    assign data_o[g*8 +: 8] = mem_q[g];
  end

  assign pull_o = pull_q;
  assign eom_o  = eom_q;
  assign good_o = good_q;
  assign irq_o  = irq_q;
  assign src_o  = src_q;
  assign cnt_o  = cnt_q;

  a_r5_no_unreg_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_q |-> (hdr_ok_q && log_addr_i != ADDR_BCAST));
  a_r5_ack_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_q |-> (tcnt_q <= thr_i.ack_len));
  a_r8_cnt_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcnt_q <= CW'(MAX_BYTES));
  a_r9_report_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eom_q) |-> ($past(state_q) == ST_ACK || $past(state_q) == ST_BWAIT));
  a_r11_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eom_q && !clr_rx_i) |=> (eom_q && state_q == ST_DONE));
  a_r11_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_rx_i |=> (!eom_q && !irq_q && !src_q));
  a_r11_data_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |=> $stable(data_o));
endmodule

// File: rtl/cec_frame_rx.sv
module cec_frame_rx
  import cec_rx_pkg::*;
#(
  parameter int unsigned MAX_BYTES   = 16,
  parameter int unsigned DIV_W       = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [DIV_W-1:0]             clk_div_i,
  input  logic                         cec_i,
  output logic                         cec_pull_o,
  input  logic [3:0]                   log_addr_i,
  input  logic                         clr_rx_i,
  input  logic [7:0]                   start_lo_min_i,
  input  logic [7:0]                   start_lo_max_i,
  input  logic [7:0]                   start_per_min_i,
  input  logic [7:0]                   start_per_max_i,
  input  logic [7:0]                   sample_pt_i,
  input  logic [7:0]                   ack_len_i,
  input  logic [7:0]                   bit_lo_max_i,
  output logic                         rx_eom_o,
  output logic                         rx_good_o,
  output logic                         rx_irq_o,
  output logic                         rx_src_o,
  output logic [$clog2(MAX_BYTES)-1:0] rx_cnt_o,
  output logic [MAX_BYTES*8-1:0]       rx_data_o
);
  logic tick, line, fall, rise;
  thr_t thr;

  assign thr.lo_min     = tick_cnt_t'(start_lo_min_i);
  assign thr.lo_max     = tick_cnt_t'(start_lo_max_i);
  assign thr.per_min    = tick_cnt_t'(start_per_min_i);
  assign thr.per_max    = tick_cnt_t'(start_per_max_i);
  assign thr.sample     = tick_cnt_t'(sample_pt_i);
  assign thr.ack_len    = tick_cnt_t'(ack_len_i);
  assign thr.bit_lo_max = tick_cnt_t'(bit_lo_max_i);

  cec_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (clk_div_i),
    .tick_o (tick)
  );

  cec_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (cec_i),
    .line_o (line),
    .fall_o (fall),
    .rise_o (rise)
  );

  cec_rx_core #(.MAX_BYTES(MAX_BYTES)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .line_i     (line),
    .fall_i     (fall),
    .rise_i     (rise),
    .log_addr_i (log_addr_i),
    .thr_i      (thr),
    .clr_rx_i   (clr_rx_i),
    .pull_o     (cec_pull_o),
    .eom_o      (rx_eom_o),
    .good_o     (rx_good_o),
    .irq_o      (rx_irq_o),
    .src_o      (rx_src_o),
    .cnt_o      (rx_cnt_o),
    .data_o     (rx_data_o)
  );
endmodule

// File: tb/sim_cec_frame_rx.sv
module sim_cec_frame_rx;
  localparam int DIV = 2;
  localparam int BIT_T = 96;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic         tb_low = 1'b0;
  logic         clr = 1'b0;
  logic [3:0]   laddr = 4'h4;
  logic         pull, eom, good, irq, src;
  logic [3:0]   cnt;
  logic [127:0] data;
  logic         bus;
  assign bus = ~(tb_low | pull);

  cec_frame_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .clk_div_i(12'(DIV)), .cec_i(bus), .cec_pull_o(pull),
    .log_addr_i(laddr), .clr_rx_i(clr),
    .start_lo_min_i(8'd140), .start_lo_max_i(8'd156),
    .start_per_min_i(8'd172), .start_per_max_i(8'd188),
    .sample_pt_i(8'd42), .ack_len_i(8'd60), .bit_lo_max_i(8'd82),
    .rx_eom_o(eom), .rx_good_o(good), .rx_irq_o(irq), .rx_src_o(src),
    .rx_cnt_o(cnt), .rx_data_o(data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] fr [0:19];
  logic       acks [0:19];
  logic       rels [0:19];

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int t);
    repeat (t*DIV) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input int lo, input int tot);
    tb_low = 1'b1; wt(lo);
    tb_low = 1'b0; wt(tot - lo);
  endtask

  task automatic send_start(input int lo, input int tot);
    send_bit(lo, tot);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic e, input int lo1, input int lo0,
                           output logic ack, output logic rel);
    for (int i = 7; i >= 0; i--) send_bit(b[i] ? lo1 : lo0, BIT_T);
    send_bit(e ? 24 : 60, BIT_T);
    tb_low = 1'b1; wt(24);
    tb_low = 1'b0; wt(18);
    ack = ~bus;
    wt(28);
    rel = bus;
    wt(BIT_T - 70);
  endtask

  task automatic send_frame(input int n);
    for (int k = 0; k < n; k++) send_byte(fr[k], k == n-1, 24, 60, acks[k], rels[k]);
    wt(20);
  endtask

  task automatic clr_pulse();
    clr = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    clr = 1'b0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    check("R1 eom", eom, 0);
    check("R1 good", good, 0);
    check("R1 irq", irq, 0);
    check("R1 src", src, 0);
    check("R1 cnt", cnt, 0);
    check("R1 pull", pull, 0);
  endtask

  task automatic t_direct();
    logic a, r;
    send_start(148, 180);
    send_byte(8'h14, 1'b0, 24, 60, a, r);
    check("R5 ack hdr", a, 1);
    check("R5 release hdr", r, 1);
    send_byte(8'hA5, 1'b0, 38, 46, a, r);  // R3 lows just around the sample point
    check("R5 ack b1", a, 1);
    send_byte(8'h3C, 1'b1, 24, 60, a, r);
    check("R5 ack b2", a, 1);
    wt(20);
    check("R9 eom", eom, 1);
    check("R9 good", good, 1);
    check("R9 irq", irq, 1);
    check("R9 src", src, 1);
    check("R7 cnt", cnt, 2);
    check("R3 R6 data", data[23:0], 24'h3CA514);
  endtask

  task automatic t_stall();
    fr[0] = 8'h14; fr[1] = 8'h99;
    send_start(148, 180);
    send_frame(2);
    check("R11 no ack while stalled", acks[0], 0);
    check("R11 data kept", data[23:0], 24'h3CA514);
    check("R11 eom held", eom, 1);
    clr = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R11 eom cleared", eom, 0);
    check("R11 irq cleared", irq, 0);
    clr = 1'b0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic t_bcast();
    fr[0] = 8'h1F; fr[1] = 8'h82;
    send_start(148, 180);
    send_frame(2);
    check("R5 bcast no ack hdr", acks[0], 0);
    check("R5 bcast no ack b1", acks[1], 0);
    check("R4 bcast eom", eom, 1);
    check("R4 bcast good", good, 1);
    check("R7 bcast cnt", cnt, 1);
    check("R6 bcast data", data[15:0], 16'h821F);
    clr_pulse();
  endtask

  task automatic t_other();
    fr[0] = 8'h17; fr[1] = 8'h55;
    send_start(148, 180);
    send_frame(2);
    check("R4 other no ack", acks[0], 0);
    check("R4 other no eom", eom, 0);
    check("R4 other data kept", data[15:0], 16'h821F);
  endtask

  task automatic t_badstart();
    fr[0] = 8'h14; fr[1] = 8'h66;
    send_start(120, 180);
    send_frame(2);
    check("R2 short low no ack", acks[0], 0);
    check("R2 short low no eom", eom, 0);
    send_start(148, 200);
    send_frame(2);
    check("R2 long period no ack", acks[0], 0);
    check("R2 long period no eom", eom, 0);
  endtask

  task automatic t_overflow();
    fr[0] = 8'h14;
    for (int k = 1; k < 18; k++) fr[k] = 8'h40 + 8'(k);
    send_start(148, 180);
    send_frame(18);
    check("R8 ack b15", acks[15], 1);
    check("R8 ack b16", acks[16], 1);
    check("R8 ack b17", acks[17], 1);
    check("R8 cnt", cnt, 15);
    check("R8 eom", eom, 1);
    check("R6 b1", data[15:8], 8'h41);
    check("R8 b15", data[127:120], 8'h4F);
    clr_pulse();
  endtask

  task automatic t_error();
    logic a, r;
    send_start(148, 180);
    send_byte(8'h14, 1'b0, 24, 60, a, r);
    send_bit(100, 130);
    wt(20);
    check("R10 eom", eom, 1);
    check("R10 good", good, 0);
    check("R10 irq", irq, 1);
    check("R10 cnt", cnt, 0);
    check("R10 hdr stored", data[7:0], 8'h14);
    clr_pulse();
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    t_reset();
    wt(30);
    t_direct();
    t_stall();
    t_bcast();
    t_other();
    t_badstart();
    t_overflow();
    t_error();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule